// File: doc/BRIEF.md
# Programmable baud clock generator

This block turns one master clock into a square-wave clock at sixteen times a chosen serial bit rate, for the transmit and receive sides of an asynchronous serial port. A four-bit select input picks one of sixteen codes. Fourteen codes give fixed rates from 50 to 9600 baud, measured in ticks of the master clock (2.4576 MHz nominal, so the 9600 baud code yields 153.6 kHz). The other two codes pass a user input straight to the output, either to run a rate the table lacks or, with a static level, to hold the output still.

The low three bits of a free-running prescale count are exported together with the master tick strobe, so further channels can build their own clocks from the same chain. Looping the slowest tap back into the user input gives 19200 baud. A source-select input chooses between the block clock itself and an external clock pin that is sampled and edge-detected. The first rising edge seen on that pin after the source switches to external is used to clear all counters instead of counting. Driving the pin high while the block clock is the source holds the counters in clear.

Top module: `baud_gen`

## Requirements
- R1: The internal index is {rate_sel[2], rate_sel[1], rate_sel[3], rate_sel[0]} (first bit is the MSB). Indices 2 to 15 select 50, 75, 134.5, 200, 600, 2400, 9600, 4800, 1800, 1200, 2400, 300, 150 and 110 baud, and each half period of baud_clk lasts 8 x round(9600 / rate) master ticks (110 baud: 696, 134.5 baud: 568, 50 baud: 1536).
- R2: For every fixed code except 1800 baud, the high and low phases of baud_clk are of equal length.
- R3: At 1800 baud each half period is 42 or 43 master ticks, and any six consecutive half periods total exactly 256 ticks, so no edge is more than one tick off its ideal place.
- R4: Indices 0 and 1 copy user_in to baud_clk one master tick later; a static user_in gives a static output.
- R5: A new select value takes effect only at the next baud_clk transition; the half period in progress finishes at its old length.
- R6: tap_out counts master ticks modulo 8, so tap_out[2] toggles every 4 ticks; fed into user_in under index 1 it gives half periods of 4 ticks.
- R7: clk_out is the master tick strobe: constantly high while the block clock is the source, and high for one cycle per counted external-clock rising edge otherwise.
- R8: With src_xtal low, counters advance once per rising edge of ext_clk and hold otherwise; the first rising edge after src_xtal falls clears tap_out and baud_clk and is not counted.
- R9: With src_xtal high, a high ext_clk holds tap_out and baud_clk at zero.
- R10: During reset tap_out and baud_clk are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the crystal-path master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_xtal | input | 1 | 1: block clock is the master; 0: ext_clk edges are the master |
| ext_clk | input | 1 | External clock pin, also the clear request in crystal mode |
| rate_sel | input | 4 | Rate select, bit order per R1 |
| user_in | input | 1 | User rate or static level for indices 0 and 1 |
| baud_clk | output | 1 | Selected 16x bit-rate clock |
| tap_out | output | 3 | Prescale taps, master ticks modulo 8 |
| clk_out | output | 1 | Master tick strobe |

## Verification
The bench sweeps all fourteen fixed codes and measures six consecutive half periods of each against 8 x round(9600/rate), so a divider off by one, an odd code mapped to the wrong rate or a broken bit reordering shows up as a wrong length. The 1800 baud code is checked for the 42/43 pattern and the 256-tick total, which an even split or a coarse 5/5/6 split would miss. A select change is made in the middle of a 50 baud half period; a design that reloaded at once would cut a runt pulse. In external mode the bench counts strobes and taps across pulses to catch an initialization edge that is counted or never cleared, and holds the pin high in crystal mode to catch a missing continuous clear.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int SEL_W   = 4;
    localparam int HALF_W  = 11;
    localparam int TAP_W   = 3;
    localparam int PHASE_W = 3;

    localparam logic [SEL_W-1:0]  IDX_1800  = 4'd10;
    localparam logic [HALF_W-1:0] HALF_MAX  = 11'd1536;

    // Half period of each fixed code in master ticks
    function automatic logic [HALF_W-1:0] half_ticks(input logic [SEL_W-1:0] idx,
                                                     input logic [PHASE_W-1:0] ph);
        logic [HALF_W-1:0] h;
        case (idx)
            4'd2:    h = 11'd1536;
            4'd3:    h = 11'd1024;
            4'd4:    h = 11'd568;
            4'd5:    h = 11'd384;
            4'd6:    h = 11'd128;
            4'd7:    h = 11'd32;
            4'd8:    h = 11'd8;
            4'd9:    h = 11'd16;
            4'd10:   h = (ph == 3'd2 || ph == 3'd5) ? 11'd42 : 11'd43;
            4'd11:   h = 11'd64;
            4'd12:   h = 11'd32;
            4'd13:   h = 11'd256;
            4'd14:   h = 11'd512;
            4'd15:   h = 11'd696;
            default: h = 11'd8;
        endcase
        return h;
    endfunction

    function automatic logic is_pass(input logic [SEL_W-1:0] idx);
        return idx[SEL_W-1:1] == '0;
    endfunction

endpackage

// File: rtl/baud_tick_src.sv
module baud_tick_src (
    input  logic clk,
    input  logic rst_n,
    input  logic src_xtal,
    input  logic ext_clk,
    output logic tick,
    output logic clr
);
    typedef struct packed {
        logic cp1;
        logic cp2;
        logic cp3;
        logic xtal_prev;
        logic armed;
    } src_st_t;

    src_st_t s_d, s_q;
    logic    rise;

    assign rise = s_q.cp2 & ~s_q.cp3;
    assign tick = src_xtal | (rise & ~s_q.armed);
    assign clr  = src_xtal ? s_q.cp2 : (rise & s_q.armed);

    always_comb begin
        s_d           = s_q;
        s_d.cp1       = ext_clk;
        s_d.cp2       = s_q.cp1;
        s_d.cp3       = s_q.cp2;
        s_d.xtal_prev = src_xtal;
        if (s_q.xtal_prev && !src_xtal)
            s_d.armed = 1'b1;
        else if (!src_xtal && rise && s_q.armed)
            s_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{cp1: 1'b0, cp2: 1'b0, cp3: 1'b0, xtal_prev: 1'b1, armed: 1'b1};
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [TAP_W-1:0] taps
);
    logic [TAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign taps = cnt_q;
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div
    import baud_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic [SEL_W-1:0]  sel_idx,
    input  logic              user_in,
    output logic              z,
    output logic              cur_pass,
    output logic [HALF_W-1:0] cnt
);
    typedef struct packed {
        logic [HALF_W-1:0]  cnt;
        logic [SEL_W-1:0]   cur;
        logic [PHASE_W-1:0] ph;
        logic               z;
    } div_st_t;

    div_st_t           s_d, s_q;
    logic [HALF_W-1:0] half;

    assign half     = half_ticks(s_q.cur, s_q.ph);
    assign cur_pass = is_pass(s_q.cur);

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
            s_d.cur = sel_idx;
            s_d.ph  = '0;
            s_d.z   = 1'b0;
        end else if (tick) begin
            if (cur_pass) begin
                s_d.z   = user_in;
                s_d.cur = sel_idx;
                s_d.cnt = '0;
                s_d.ph  = '0;
            end else if (s_q.cnt == half - 1'b1) begin
                s_d.z   = ~s_q.z;
                s_d.cnt = '0;
                s_d.cur = sel_idx;
                if (sel_idx == s_q.cur && s_q.cur == IDX_1800)
                    s_d.ph = (s_q.ph == 3'd5) ? '0 : s_q.ph + 1'b1;
                else
                    s_d.ph = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign z   = s_q.z;
    assign cnt = s_q.cnt;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_xtal,
    input  logic             ext_clk,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             user_in,
    output logic             baud_clk,
    output logic [TAP_W-1:0] tap_out,
    output logic             clk_out
);
    logic              tick;
    logic              clr;
    logic              cur_pass;
    logic [HALF_W-1:0] div_cnt;
    logic [SEL_W-1:0]  sel_idx;

    // Index bit order is part of the select behaviour
    assign sel_idx = {rate_sel[2], rate_sel[1], rate_sel[3], rate_sel[0]};

    baud_tick_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_xtal (src_xtal),
        .ext_clk  (ext_clk),
        .tick     (tick),
        .clr      (clr)
    );

    baud_prescaler #(.TAP_W(TAP_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (clr),
        .taps  (tap_out)
    );

    baud_rate_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (clr),
        .sel_idx  (sel_idx),
        .user_in  (user_in),
        .z        (baud_clk),
        .cur_pass (cur_pass),
        .cnt      (div_cnt)
    );

    assign clk_out = tick;
endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker
    import baud_gen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              clr,
    input logic              cur_pass,
    input logic              user_in,
    input logic              baud_clk,
    input logic [TAP_W-1:0]  tap_out,
    input logic [HALF_W-1:0] div_cnt
);
    // R6: taps advance by one on each counted tick
    p_tap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> tap_out == TAP_W'($past(tap_out) + 1'b1));

    // R8 R9: a clear zeroes taps and output
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tap_out == '0 && baud_clk == 1'b0));

    // R8: nothing moves without a tick
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> ($stable(tap_out) && $stable(baud_clk)));

    // R4: pass-through codes copy the user input
    p_pass_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pass && tick && !clr) |=> baud_clk == $past(user_in));

    // R1: half-period counter stays below the longest half period
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < HALF_MAX);
endmodule

bind baud_gen baud_gen_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (clr),
    .cur_pass (cur_pass),
    .user_in  (user_in),
    .baud_clk (baud_clk),
    .tap_out  (tap_out),
    .div_cnt  (div_cnt)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_xtal = 1'b1;
    logic       ext_clk = 1'b0;
    logic       im_drv = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       baud_clk;
    logic [2:0] tap_out;
    logic       clk_out;
    wire        user_in = loop_en ? tap_out[2] : im_drv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    baud_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_xtal (src_xtal),
        .ext_clk  (ext_clk),
        .rate_sel (rate_sel),
        .user_in  (user_in),
        .baud_clk (baud_clk),
        .tap_out  (tap_out),
        .clk_out  (clk_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] to_sel(input int idx);
        logic [3:0] i;
        i = 4'(idx);
        return {i[1], i[3], i[2], i[0]};
    endfunction

    function automatic real rate_of(input int idx);
        case (idx)
            2: return 50.0;    3: return 75.0;    4: return 134.5;
            5: return 200.0;   6: return 600.0;   7: return 2400.0;
            8: return 9600.0;  9: return 4800.0;  10: return 1800.0;
            11: return 1200.0; 12: return 2400.0; 13: return 300.0;
            14: return 150.0;  default: return 110.0;
        endcase
    endfunction

    function automatic int exp_half(input int idx);
        return 8 * $rtoi(9600.0 / rate_of(idx) + 0.5);
    endfunction

    task automatic wait_edge();
        logic p;
        int n;
        p = baud_clk;
        n = 0;
        while (baud_clk == p && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic half_len(output int n);
        logic p;
        p = baud_clk;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (baud_clk == p && n < 5000);
    endtask

    task automatic pulse(inout int strobes);
        ext_clk = 1'b1;
        repeat (4) begin @(negedge clk); strobes += int'(clk_out); end
        ext_clk = 1'b0;
        repeat (4) begin @(negedge clk); strobes += int'(clk_out); end
    endtask

    initial begin
        int t, n, sum, bad, strobes;
        int h[6];

        // R10: reset state
        repeat (4) @(negedge clk);
        chk(tap_out == 3'd0, "R10 taps", int'(tap_out), 0);
        chk(baud_clk == 1'b0, "R10 baud_clk", int'(baud_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R7: taps count ticks, strobe high in crystal mode
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            t = int'(tap_out);
            @(negedge clk);
            if (int'(tap_out) != (t + 1) % 8) bad++;
            if (clk_out != 1'b1) bad++;
        end
        chk(bad == 0, "R6 R7 tap step and strobe", bad, 0);

        // R4: static pass-through under index 0
        im_drv = 1'b1;
        repeat (3) @(negedge clk);
        chk(baud_clk == 1'b1, "R4 pass high", int'(baud_clk), 1);
        im_drv = 1'b0;
        repeat (3) @(negedge clk);
        chk(baud_clk == 1'b0, "R4 pass low", int'(baud_clk), 0);
        bad = 0;
        repeat (200) begin @(negedge clk); if (baud_clk) bad++; end
        chk(bad == 0, "R4 zero baud static", bad, 0);

        // R1 R2 R3: sweep every fixed code
        for (int idx = 2; idx < 16; idx++) begin
            rate_sel = to_sel(idx);
            wait_edge();
            for (int k = 0; k < 6; k++) half_len(h[k]);
            if (idx == 10) begin
                sum = 0;
                bad = 0;
                for (int k = 0; k < 6; k++) begin
                    sum += h[k];
                    if (h[k] != 42 && h[k] != 43) bad++;
                end
                chk(sum == 256, "R3 six halves total", sum, 256);
                chk(bad == 0, "R3 halves 42 or 43", bad, 0);
            end else begin
                for (int k = 0; k < 6; k++)
                    chk(h[k] == exp_half(idx), $sformatf("R1 R2 index %0d half %0d", idx, k),
                        h[k], exp_half(idx));
            end
        end
        $display("info: 110 baud code gives %f baud",
                 2457600.0 / (16.0 * real'(exp_half(15) * 2)));

        // R5: change in mid half period finishes old half first
        rate_sel = to_sel(2);
        wait_edge();
        wait_edge();
        repeat (100) @(negedge clk);
        rate_sel = to_sel(8);
        half_len(n);
        chk(n + 100 == 1536, "R5 old half completes", n + 100, 1536);
        half_len(n);
        chk(n == 8, "R5 new half after edge", n, 8);

        // R6 R4: tap loop under index 1 gives 19200 baud
        rate_sel = to_sel(1);
        loop_en = 1'b1;
        repeat (30) @(negedge clk);
        wait_edge();
        for (int k = 0; k < 4; k++) begin
            half_len(n);
            chk(n == 4, "R6 loop half", n, 4);
        end
        loop_en = 1'b0;

        // R8 R7: external clock mode with one-shot clear
        rate_sel = to_sel(8);
        repeat (30) @(negedge clk);
        ext_clk = 1'b0;
        src_xtal = 1'b0;
        repeat (5) @(negedge clk);
        t = int'(tap_out);
        repeat (10) @(negedge clk);
        chk(int'(tap_out) == t, "R8 hold without edges", int'(tap_out), t);
        strobes = 0;
        pulse(strobes);
        repeat (4) @(negedge clk);
        chk(tap_out == 3'd0, "R8 first edge clears taps", int'(tap_out), 0);
        chk(baud_clk == 1'b0, "R8 first edge clears output", int'(baud_clk), 0);
        chk(strobes == 0, "R8 first edge not counted", strobes, 0);
        strobes = 0;
        for (int k = 0; k < 11; k++) pulse(strobes);
        repeat (4) @(negedge clk);
        chk(strobes == 11, "R7 one strobe per edge", strobes, 11);
        chk(tap_out == 3'd3, "R8 taps after 11 edges", int'(tap_out), 3);
        chk(baud_clk == 1'b1, "R8 R1 toggle after 8 edges", int'(baud_clk), 1);

        // R9: crystal mode with ext_clk high holds clear
        ext_clk = 1'b1;
        src_xtal = 1'b1;
        repeat (4) @(negedge clk);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (tap_out != 3'd0 || baud_clk != 1'b0) bad++;
        end
        chk(bad == 0, "R9 continuous clear", bad, 0);
        ext_clk = 1'b0;
        repeat (5) @(negedge clk);
        t = int'(tap_out);
        @(negedge clk);
        chk(int'(tap_out) == (t + 1) % 8, "R9 counting resumes", int'(tap_out), (t + 1) % 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule